// File: doc/BRIEF.md
# Switch-Configured Register and ALU Datapath

This block is a small processor datapath with no instruction fetch. External control settings configure every pass through it. Two read selectors pick the registers that drive the A and B operand buses. An operation selector picks the ALU function. A destination selector picks the register that the C bus writes. Two bus switches decide where data flows: the C-bus switch and the memory-bus switch. A memory address selector picks one word of a small on-block memory.

Each execute strobe runs one datapath pass in a fixed order:

- read the operands,
- compute the result,
- wait out the memory latency if memory takes part,
- commit the write.

A one-clock done pulse marks the end of the pass. Between passes, a direct-entry port lets a user place values straight into a register or a memory word. The selected registers and memory word can be viewed continuously.

The two switches set the mode of a pass:

| C-bus switch | Memory-bus switch | Mode |
|---|---|---|
| 1 | 0 | Register operation |
| 0 | 1 | Memory load into a register |
| 1 | 1 | ALU result stored directly to memory, without passing through a register |
| 0 | 0 | Pass with no write |

Top module: `knob_datapath`

## Requirements
- R1: After reset the following are all zero: every register, every memory word, `busy_o`, `done_o` and `c_bus_o`.
- R2: While the datapath is idle, `entry_i` writes `entry_data_i` into one location. With `entry_to_mem_i`=0 the target is register `c_sel_i`. With `entry_to_mem_i`=1 the target is memory word `mem_addr_i`. Any entry made while `busy_o` is high is ignored.
- R3: The operation codes on `alu_op_i` are 0 = A+B, 1 = A−B, 2 = A AND B and 3 = A OR B. The arithmetic wraps modulo 2^16.
- R4: A pass with `c_sw_i`=1 and `m_sw_i`=0 writes op(reg[a_sel], reg[b_sel]) into reg[c_sel]. The three selectors are independent, and the destination may be one of the sources. `done_o` rises after the third rising edge following the edge that accepts execute.
- R5: A pass with `m_sw_i`=1 and `c_sw_i`=0 copies memory word `mem_addr_i` into reg[c_sel]. The A selector, the B selector and the operation have no effect on this pass. `done_o` comes MEM_WAIT clocks later than in R4 (five clocks by default).
- R6: A pass with both switches at 1 writes the ALU result into memory word `mem_addr_i`. No register changes. The timing is the same as R5.
- R7: A pass with both switches at 0 changes no register and no memory word. The timing is the same as R4.
- R8: `exec_i` is ignored while `busy_o` is high. All settings are captured on the accepting edge, so changes to the selector and switch inputs during a pass do not affect it.
- R9: `done_o` is high for exactly one clock. `busy_o` is high from the clock after acceptance until the done clock, and it is low in the done clock itself.
- R10: Memory addresses 33 to 63 are unmapped. A load from one returns zero, `mem_view_o` shows zero for one, and a store or an entry to one is dropped.
- R11: `c_bus_o` holds the value that the last pass placed on the C bus: the loaded word for a load, or the ALU result otherwise. It does not change while the datapath is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_i | input | 1 | Start one datapath pass |
| a_sel_i | input | 2 | A-bus register select |
| b_sel_i | input | 2 | B-bus register select |
| c_sel_i | input | 2 | C-bus destination register select; also the entry target register |
| alu_op_i | input | 2 | ALU operation code |
| c_sw_i | input | 1 | C-bus switch (1 = connected) |
| m_sw_i | input | 1 | Memory-bus switch (1 = connected) |
| mem_addr_i | input | 6 | Memory word select |
| entry_i | input | 1 | Direct-entry strobe |
| entry_to_mem_i | input | 1 | Direct-entry target: 1 = memory, 0 = register |
| entry_data_i | input | 16 | Direct-entry value |
| a_view_o | output | 16 | Register selected by `a_sel_i`, shown combinationally |
| b_view_o | output | 16 | Register selected by `b_sel_i`, shown combinationally |
| mem_view_o | output | 16 | Word at `mem_addr_i`, shown one clock later |
| c_bus_o | output | 16 | Value on the C bus from the last pass |
| busy_o | output | 1 | A pass is in progress |
| done_o | output | 1 | One-clock pulse at the end of a pass |

## Verification
Suppose an operand latch or a captured setting is wrong. The error reaches `c_bus_o` at the done pulse of that same pass. A wrong destination write shows up at once on the view ports when the affected register is selected. A miscounted memory wait moves the done pulse off the five-clock mark, so it is caught on the first memory pass. A sequencer that accepts a second execute while busy produces an extra done pulse that no queued pass accounts for.

// File: rtl/kdp_pkg.sv
package kdp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_ALU,
        ST_WAIT,
        ST_WRITE
    } kdp_state_e;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_OR  = 2'd3
    } kdp_op_e;
endpackage

// File: rtl/kdp_alu.sv
module kdp_alu #(
    parameter int DW = 16
) (
    input  kdp_pkg::kdp_op_e op_i,
    input  logic [DW-1:0]    a_i,
    input  logic [DW-1:0]    b_i,
    output logic [DW-1:0]    y_o
);
    import kdp_pkg::*;

    always_comb begin
        unique case (op_i)
            OP_ADD:  y_o = a_i + b_i;
            OP_SUB:  y_o = a_i - b_i;
            OP_AND:  y_o = a_i & b_i;
            default: y_o = a_i | b_i;
        endcase
    end
endmodule

// File: rtl/kdp_regfile.sv
module kdp_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 4,
    parameter int NRD  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic [RAW-1:0]          wa_i,
    input  logic [DW-1:0]           wd_i,
    input  logic [NRD*RAW-1:0]      ra_i,
    output logic [NRD*DW-1:0]       rd_o
);
    localparam int RAW = (NREG > 1) ? $clog2(NREG) : 1;

    logic [DW-1:0] regs_q [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else if (we_i && (int'(wa_i) < NREG)) begin
            regs_q[wa_i] <= wd_i;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_o[g*DW +: DW] = regs_q[ra_i[g*RAW +: RAW]];
    end
endmodule

// File: rtl/kdp_mem.sv
module kdp_mem #(
    parameter int DW    = 16,
    parameter int DEPTH = 33,
    parameter int NRD   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_i,
    input  logic [AW-1:0]       wa_i,
    input  logic [DW-1:0]       wd_i,
    input  logic [NRD*AW-1:0]   ra_i,
    output logic [NRD*DW-1:0]   rd_o
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                words_q[i] <= '0;
            end
        end else if (we_i && (int'(wa_i) < DEPTH)) begin
            words_q[wa_i] <= wd_i;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        logic [AW-1:0] addr;
        logic [DW-1:0] data_q;
        assign addr = ra_i[g*AW +: AW];
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q <= '0;
            end else if (int'(addr) < DEPTH) begin
                data_q <= words_q[addr];
            end else begin
                data_q <= '0;
            end
        end
        assign rd_o[g*DW +: DW] = data_q;
    end
endmodule

// File: rtl/knob_datapath.sv
module knob_datapath #(
    parameter int DW        = 16,
    parameter int NREG      = 4,
    parameter int MEM_DEPTH = 33,
    parameter int MEM_WAIT  = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           exec_i,
    input  logic [$clog2(NREG)-1:0]        a_sel_i,
    input  logic [$clog2(NREG)-1:0]        b_sel_i,
    input  logic [$clog2(NREG)-1:0]        c_sel_i,
    input  logic [1:0]                     alu_op_i,
    input  logic                           c_sw_i,
    input  logic                           m_sw_i,
    input  logic [$clog2(MEM_DEPTH)-1:0]   mem_addr_i,
    input  logic                           entry_i,
    input  logic                           entry_to_mem_i,
    input  logic [DW-1:0]                  entry_data_i,
    output logic [DW-1:0]                  a_view_o,
    output logic [DW-1:0]                  b_view_o,
    output logic [DW-1:0]                  mem_view_o,
    output logic [DW-1:0]                  c_bus_o,
    output logic                           busy_o,
    output logic                           done_o
);
    import kdp_pkg::*;

    localparam int RAW = $clog2(NREG);
    localparam int MAW = $clog2(MEM_DEPTH);
    localparam int CW  = (MEM_WAIT > 1) ? $clog2(MEM_WAIT) : 1;

    typedef struct packed {
        kdp_state_e     st;
        logic [RAW-1:0] a_sel;
        logic [RAW-1:0] b_sel;
        logic [RAW-1:0] c_sel;
        kdp_op_e        op;
        logic           c_sw;
        logic           m_sw;
        logic [MAW-1:0] maddr;
        logic [DW-1:0]  a;
        logic [DW-1:0]  b;
        logic [DW-1:0]  c;
        logic [CW-1:0]  cnt;
        logic           done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [4*DW-1:0]  rf_rd;
    logic [2*DW-1:0]  mem_rd;
    logic [DW-1:0]    alu_y;
    logic [DW-1:0]    mem_word;
    logic             idle;
    logic             commit;
    logic             rf_we;
    logic [RAW-1:0]   rf_wa;
    logic [DW-1:0]    rf_wd;
    logic             mem_we;
    logic [MAW-1:0]   mem_wa;
    logic [DW-1:0]    mem_wd;

    assign idle     = (seq_q.st == ST_IDLE);
    assign commit   = (seq_q.st == ST_WRITE);
    assign mem_word = mem_rd[DW-1:0];

    // Sequencer next state: read, compute, optional wait, write
    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (exec_i) begin
                    seq_d.st    = ST_READ;
                    seq_d.a_sel = a_sel_i;
                    seq_d.b_sel = b_sel_i;
                    seq_d.c_sel = c_sel_i;
                    seq_d.op    = kdp_op_e'(alu_op_i);
                    seq_d.c_sw  = c_sw_i;
                    seq_d.m_sw  = m_sw_i;
                    seq_d.maddr = mem_addr_i;
                end
            end
            ST_READ: begin
                seq_d.a  = rf_rd[0*DW +: DW];
                seq_d.b  = rf_rd[1*DW +: DW];
                seq_d.st = ST_ALU;
            end
            ST_ALU: begin
                seq_d.c = alu_y;
                if (seq_q.m_sw && (MEM_WAIT > 0)) begin
                    seq_d.cnt = CW'(MEM_WAIT - 1);
                    seq_d.st  = ST_WAIT;
                end else begin
                    seq_d.st = ST_WRITE;
                end
            end
            ST_WAIT: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st = ST_WRITE;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_WRITE: begin
                if (seq_q.m_sw && !seq_q.c_sw) begin
                    seq_d.c = mem_word;
                end
                seq_d.done = 1'b1;
                seq_d.st   = ST_IDLE;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, op: OP_ADD, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    // Register write port: direct entry when idle, or commit of a pass
    always_comb begin
        if (commit) begin
            rf_we = seq_q.c_sw ^ seq_q.m_sw;
            rf_wa = seq_q.c_sel;
            rf_wd = seq_q.m_sw ? mem_word : seq_q.c;
        end else begin
            rf_we = idle && entry_i && !entry_to_mem_i;
            rf_wa = c_sel_i;
            rf_wd = entry_data_i;
        end
    end

    // Memory write port: direct store of the ALU result, or direct entry
    always_comb begin
        if (commit) begin
            mem_we = seq_q.c_sw && seq_q.m_sw;
            mem_wa = seq_q.maddr;
            mem_wd = seq_q.c;
        end else begin
            mem_we = idle && entry_i && entry_to_mem_i;
            mem_wa = mem_addr_i;
            mem_wd = entry_data_i;
        end
    end

    kdp_regfile #(
        .DW   (DW),
        .NREG (NREG),
        .NRD  (4)
    ) u_regfile (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (rf_we),
        .wa_i  (rf_wa),
        .wd_i  (rf_wd),
        .ra_i  ({b_sel_i, a_sel_i, seq_q.b_sel, seq_q.a_sel}),
        .rd_o  (rf_rd)
    );

    kdp_alu #(
        .DW (DW)
    ) u_alu (
        .op_i (seq_q.op),
        .a_i  (seq_q.a),
        .b_i  (seq_q.b),
        .y_o  (alu_y)
    );

    kdp_mem #(
        .DW    (DW),
        .DEPTH (MEM_DEPTH),
        .NRD   (2)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (mem_we),
        .wa_i  (mem_wa),
        .wd_i  (mem_wd),
        .ra_i  ({mem_addr_i, seq_q.maddr}),
        .rd_o  (mem_rd)
    );

    assign a_view_o   = rf_rd[2*DW +: DW];
    assign b_view_o   = rf_rd[3*DW +: DW];
    assign mem_view_o = mem_rd[DW +: DW];
    assign c_bus_o    = seq_q.c;
    assign busy_o     = !idle;
    assign done_o     = seq_q.done;
endmodule

// File: rtl/kdp_checker.sv
module kdp_checker #(
    parameter int DW       = 16,
    parameter int MEM_WAIT = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          exec_i,
    input logic          busy_o,
    input logic          done_o,
    input logic [DW-1:0] c_bus_o
);
    logic [7:0] lat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (!busy_o && exec_i) begin
            lat_q <= '0;
        end else if (busy_o && lat_q != 8'hFF) begin
            lat_q <= lat_q + 8'd1;
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R9
    busy_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o));

    // R8
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && exec_i) |=> busy_o);

    // R4
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (int'(lat_q) == 3 || int'(lat_q) == 3 + MEM_WAIT));

    // R11
    cbus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(c_bus_o));
endmodule

bind knob_datapath kdp_checker #(
    .DW       (DW),
    .MEM_WAIT (MEM_WAIT)
) u_kdp_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .exec_i  (exec_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .c_bus_o (c_bus_o)
);

// File: tb/knob_datapath_bench.sv
module knob_datapath_bench;
    localparam int DW = 16;
    localparam int MEM_WAIT = 2;
    localparam int DEPTH = 33;
    localparam int LAT_REG = 4;
    localparam int LAT_MEM = 4 + MEM_WAIT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic exec_i = 1'b0;
    logic [1:0] a_sel_i = '0, b_sel_i = '0, c_sel_i = '0, alu_op_i = '0;
    logic c_sw_i = 1'b0, m_sw_i = 1'b0;
    logic [5:0] mem_addr_i = '0;
    logic entry_i = 1'b0, entry_to_mem_i = 1'b0;
    logic [DW-1:0] entry_data_i = '0;
    logic [DW-1:0] a_view_o, b_view_o, mem_view_o, c_bus_o;
    logic busy_o, done_o;

    always #5 clk = ~clk;

    knob_datapath u_knob_datapath (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i),
        .a_sel_i(a_sel_i), .b_sel_i(b_sel_i), .c_sel_i(c_sel_i),
        .alu_op_i(alu_op_i), .c_sw_i(c_sw_i), .m_sw_i(m_sw_i),
        .mem_addr_i(mem_addr_i), .entry_i(entry_i),
        .entry_to_mem_i(entry_to_mem_i), .entry_data_i(entry_data_i),
        .a_view_o(a_view_o), .b_view_o(b_view_o), .mem_view_o(mem_view_o),
        .c_bus_o(c_bus_o), .busy_o(busy_o), .done_o(done_o)
    );

    typedef struct {
        string         tag;
        logic [DW-1:0] c;
        int            lat;
        int            start;
    } item_t;

    item_t sb[$];
    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    logic prev_done = 1'b0;
    logic [DW-1:0] m_rf [4];
    logic [DW-1:0] m_mem [DEPTH];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Monitor: pops one expected item per done pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                chk("R9", "done width", int'(prev_done), 0);
                if (sb.size() == 0) begin
                    chk("R8", "unexpected done", 1, 0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    chk(it.tag, "c_bus", int'(c_bus_o), int'(it.c));
                    chk(it.tag, "latency", cyc - it.start, it.lat);
                end
            end
            prev_done = done_o;
        end
    end

    function automatic logic [DW-1:0] alu_ref(input logic [1:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
        case (op)
            2'd0: return a + b;
            2'd1: return a - b;
            2'd2: return a & b;
            default: return a | b;
        endcase
    endfunction

    task automatic poke_reg(input int r, input logic [DW-1:0] v);
        @(negedge clk);
        entry_i = 1'b1; entry_to_mem_i = 1'b0; c_sel_i = 2'(r); entry_data_i = v;
        @(negedge clk);
        entry_i = 1'b0;
        m_rf[r] = v;
    endtask

    task automatic poke_mem(input int addr, input logic [DW-1:0] v);
        @(negedge clk);
        entry_i = 1'b1; entry_to_mem_i = 1'b1; mem_addr_i = 6'(addr); entry_data_i = v;
        @(negedge clk);
        entry_i = 1'b0;
        if (addr < DEPTH) m_mem[addr] = v;
    endtask

    task automatic check_regs(input string tag);
        for (int r = 0; r < 4; r++) begin
            @(negedge clk);
            a_sel_i = 2'(r); b_sel_i = 2'(3 - r);
            #1;
            chk(tag, "a_view", int'(a_view_o), int'(m_rf[r]));
            chk(tag, "b_view", int'(b_view_o), int'(m_rf[3 - r]));
        end
    endtask

    task automatic check_mem(input string tag, input int addr);
        @(negedge clk);
        mem_addr_i = 6'(addr);
        @(negedge clk);
        chk(tag, "mem_view", int'(mem_view_o), (addr < DEPTH) ? int'(m_mem[addr]) : 0);
    endtask

    // Driver: computes the expected result, pushes it, runs one pass
    task automatic run(input string tag, input int a, input int b, input int c,
                       input int op, input bit csw, input bit msw, input int addr,
                       input bit disturb);
        item_t it;
        logic [DW-1:0] y, w;
        int g;
        y = alu_ref(2'(op), m_rf[a], m_rf[b]);
        w = (addr < DEPTH) ? m_mem[addr] : '0;
        it.tag = tag;
        if (csw && !msw) begin
            m_rf[c] = y; it.c = y; it.lat = LAT_REG;
        end else if (msw && !csw) begin
            m_rf[c] = w; it.c = w; it.lat = LAT_MEM;
        end else if (msw && csw) begin
            if (addr < DEPTH) m_mem[addr] = y;
            it.c = y; it.lat = LAT_MEM;
        end else begin
            it.c = y; it.lat = LAT_REG;
        end
        @(negedge clk);
        it.start = cyc;
        sb.push_back(it);
        a_sel_i = 2'(a); b_sel_i = 2'(b); c_sel_i = 2'(c); alu_op_i = 2'(op);
        c_sw_i = csw; m_sw_i = msw; mem_addr_i = 6'(addr); exec_i = 1'b1;
        @(negedge clk);
        exec_i = 1'b0;
        if (disturb) begin
            chk("R9", "busy mid-pass", int'(busy_o), 1);
            // R8: a second execute and changed knobs; R2: an entry while busy
            exec_i = 1'b1; a_sel_i = ~a_sel_i; b_sel_i = ~b_sel_i; c_sel_i = 2'd3;
            alu_op_i = ~alu_op_i; c_sw_i = ~c_sw_i; m_sw_i = ~m_sw_i; mem_addr_i = 6'd1;
            entry_i = 1'b1; entry_to_mem_i = 1'b0; entry_data_i = 16'hDEAD;
            @(negedge clk);
            exec_i = 1'b0; entry_i = 1'b0;
        end
        g = 0;
        while (sb.size() != 0 && g < 40) begin
            @(negedge clk);
            g++;
        end
        if (sb.size() != 0) begin
            chk(tag, "no done", 0, 1);
            sb.delete();
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(10 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_rf[i] = '0;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1", "busy", int'(busy_o), 0);
        chk("R1", "done", int'(done_o), 0);
        chk("R1", "c_bus", int'(c_bus_o), 0);
        check_regs("R1");
        check_mem("R1", 0);
        check_mem("R1", 32);

        poke_reg(0, 16'h1234);
        poke_reg(1, 16'h0F0F);
        poke_reg(2, 16'hFFF0);
        poke_reg(3, 16'h0011);
        check_regs("R2");
        poke_mem(5, 16'h0100);
        poke_mem(6, 16'h0023);
        poke_mem(32, 16'hBEEF);
        poke_mem(40, 16'h7777);
        check_mem("R2", 5);
        check_mem("R2", 6);
        check_mem("R2", 32);
        check_mem("R10", 40);

        run("R4", 0, 1, 2, 0, 1'b1, 1'b0, 0, 1'b0);
        run("R3", 1, 0, 3, 1, 1'b1, 1'b0, 0, 1'b0);
        run("R3", 0, 1, 0, 2, 1'b1, 1'b0, 0, 1'b0);
        run("R3", 2, 3, 1, 3, 1'b1, 1'b0, 0, 1'b0);
        run("R3", 2, 2, 3, 0, 1'b1, 1'b0, 0, 1'b0);
        check_regs("R4");

        run("R5", 3, 2, 0, 1, 1'b0, 1'b1, 5, 1'b0);
        run("R5", 0, 0, 1, 2, 1'b0, 1'b1, 6, 1'b0);
        check_regs("R5");

        run("R6", 0, 1, 2, 0, 1'b1, 1'b1, 7, 1'b0);
        run("R6", 3, 0, 0, 3, 1'b1, 1'b1, 32, 1'b0);
        check_mem("R6", 7);
        check_mem("R6", 32);
        check_regs("R6");

        run("R7", 0, 1, 2, 2, 1'b0, 1'b0, 5, 1'b0);
        check_regs("R7");
        check_mem("R7", 5);

        run("R8", 0, 1, 2, 0, 1'b1, 1'b0, 5, 1'b1);
        check_regs("R8");
        check_mem("R8", 5);

        run("R10", 1, 2, 3, 0, 1'b0, 1'b1, 40, 1'b0);
        run("R10", 0, 1, 2, 3, 1'b1, 1'b1, 50, 1'b0);
        check_regs("R10");
        check_mem("R10", 50);
        check_mem("R10", 32);

        @(negedge clk);
        #1;
        chk("R11", "c_bus idle hold", int'(c_bus_o), int'(alu_ref(2'd3, m_rf[0], m_rf[1])));
        chk("R9", "busy idle", int'(busy_o), 0);

        summary();
        $finish;
    end
endmodule